// File: doc/BRIEF.md
# Virtual Mode Privilege and Prefix Checker

This block sits beside an instruction decoder and decides, once per decoded instruction, whether the instruction may execute or must fault. It looks at the instruction's class, its lock prefix, whether it writes memory, its byte length, the current I/O privilege level (IOPL), the current privilege level and a flag that says whether the core is running legacy 16-bit code in virtual mode. Its verdict is pass, general-protection fault (vector 13) or undefined-opcode fault (vector 6). With the verdict it drives a bus-lock indication for the memory cycle.

The set of instructions that depend on privilege changes with the mode flag. In virtual mode the current privilege is taken as 3. In that mode the flag, stack-flag and interrupt-return instructions and lock prefixes trap when IOPL is below 3. The port I/O instructions skip IOPL in that mode and depend only on the I/O permission bitmap. Outside virtual mode, port I/O is checked against IOPL first and the bitmap is used only when that check fails. The bitmap itself is kept elsewhere. The checker sends a port address over a request/response handshake and gets back the permission bits for four consecutive ports.

Top module: `vm_insn_guard`

## Requirements
- R1: An instruction whose length is above 15 bytes yields verdict 1 (general protection) with vector 13 in the cycle after acceptance. This outranks every other outcome.
- R2: A lock prefix yields verdict 2 (undefined opcode) with vector 6 when the class is outside codes 16..30 or the memory-destination flag is low. Codes 16..30 are the lockable read-modify-write classes, and code 16 is the exchange.
- R3: With the mode flag high, the checker takes the current privilege as 3 whatever the privilege input says. Classes 1 (clear interrupt flag), 2 (set interrupt flag), 3 (push flags), 4 (pop flags), 5 (software interrupt) and 6 (interrupt return), and any legal lock prefix, then yield verdict 1 with vector 13 when IOPL is below 3, and pass when IOPL is 3.
- R4: With the mode flag high, the I/O classes 8, 9, 10 and 11 ignore IOPL and always issue a bitmap request.
- R5: A bitmap response traps (verdict 1, vector 13) when any bit is set among the ports the access covers. The access width code is 0 for 1 port, 1 for 2 ports, and 2 or 3 for 4 ports, and bit k of the response belongs to the requested port plus k. Otherwise the verdict is pass (verdict 0, vector 0).
- R6: With the mode flag low, classes 1 and 2 trap with vector 13 when the current privilege is above IOPL. Classes 3 to 6 and lock prefixes do not depend on privilege in this mode.
- R7: With the mode flag low, an I/O class passes without a bitmap request when the current privilege is at or below IOPL. Otherwise it issues a bitmap request.
- R8: The bus-lock output is high only together with a pass verdict. It is high when a legal lock prefix is present, or when the class is the exchange (16) with a memory destination.
- R9: ready is low while a bitmap request is pending. The request stays high with a stable port until it is acknowledged. The verdict appears in the cycle after the acknowledge.
- R10: After reset, ready is high and the verdict strobe and bitmap request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Decoded instruction present |
| ready_o | output | 1 | Checker can accept an instruction |
| cls_i | input | 5 | Instruction class code |
| lock_i | input | 1 | Lock prefix present |
| mem_dst_i | input | 1 | Destination operand is in memory |
| len_i | input | 5 | Instruction length in bytes |
| iopl_i | input | 2 | I/O privilege level |
| cpl_i | input | 2 | Current privilege level |
| vm_i | input | 1 | Virtual mode flag |
| port_i | input | 16 | I/O port address |
| io_width_i | input | 2 | I/O access width code |
| bm_req_o | output | 1 | Bitmap lookup request |
| bm_port_o | output | 16 | Port address of the lookup |
| bm_ack_i | input | 1 | Bitmap response valid |
| bm_bits_i | input | 4 | Permission bits for ports port..port+3 (1 = deny) |
| done_o | output | 1 | Verdict strobe |
| verdict_o | output | 2 | 0 pass, 1 general protection, 2 undefined opcode |
| vector_o | output | 8 | Exception vector, 0 on pass |
| bus_lock_o | output | 1 | Assert bus lock for this instruction |

## Verification
Several checks can apply to one instruction in the same cycle. An overlong instruction can also carry an illegal lock prefix. An exchange can carry a lock prefix while IOPL is below 3 in virtual mode. An I/O instruction can be both over-length and privilege-deficient. Directed cases build each of these overlaps, and weighted random stimulus hits them often. Each result is judged against a bench model that applies the priority order: the winner sets the vector, no bitmap request is made when an earlier check has already decided the verdict, and bus lock goes low whenever the verdict is a fault.

// File: rtl/vm_guard_pkg.sv
package vm_guard_pkg;
  localparam int CLS_W = 5;
  localparam logic [CLS_W-1:0] CLS_CLI   = 5'd1;
  localparam logic [CLS_W-1:0] CLS_STI   = 5'd2;
  localparam logic [CLS_W-1:0] CLS_PUSHF = 5'd3;
  localparam logic [CLS_W-1:0] CLS_IRET  = 5'd6;
  localparam logic [CLS_W-1:0] CLS_IO_LO = 5'd8;
  localparam logic [CLS_W-1:0] CLS_IO_HI = 5'd11;
  localparam logic [CLS_W-1:0] CLS_XCHG  = 5'd16;
  localparam logic [CLS_W-1:0] CLS_LK_HI = 5'd30;

  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_UD = 8'd6;

  typedef enum logic [1:0] {
    VERD_PASS = 2'd0,
    VERD_GP   = 2'd1,
    VERD_UD   = 2'd2
  } verdict_e;

  function automatic logic [7:0] vec_of(verdict_e v);
    case (v)
      VERD_GP: return VEC_GP;
      VERD_UD: return VEC_UD;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/vm_guard_classify.sv
module vm_guard_classify
  import vm_guard_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 15
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic             lock_i,
  input  logic             mem_dst_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       iopl_i,
  input  logic [1:0]       cpl_i,
  input  logic             vm_i,
  output verdict_e         verdict_o,
  output logic             need_bm_o,
  output logic             lock_bus_o
);
  logic       len_bad, lockable, lock_bad, priv_ok;
  logic       is_if, is_vm_only, is_io, sens;
  logic [1:0] eff_cpl;

  always_comb begin
    len_bad    = int'(len_i) > MAX_LEN;
    lockable   = (cls_i >= CLS_XCHG) && (cls_i <= CLS_LK_HI);
    lock_bad   = lock_i && !(lockable && mem_dst_i);
    eff_cpl    = vm_i ? 2'd3 : cpl_i;   // virtual mode runs at privilege 3
    priv_ok    = eff_cpl <= iopl_i;
    is_if      = (cls_i == CLS_CLI) || (cls_i == CLS_STI);
    is_vm_only = (cls_i >= CLS_PUSHF) && (cls_i <= CLS_IRET);
    is_io      = (cls_i >= CLS_IO_LO) && (cls_i <= CLS_IO_HI);
    sens       = is_if || (vm_i && (is_vm_only || lock_i));

    verdict_o  = VERD_PASS;
    need_bm_o  = 1'b0;
    if (len_bad)               verdict_o = VERD_GP;
    else if (lock_bad)         verdict_o = VERD_UD;
    else if (sens && !priv_ok) verdict_o = VERD_GP;
    else if (is_io && (vm_i || !priv_ok)) need_bm_o = 1'b1;

    lock_bus_o = (lock_i && !lock_bad) || ((cls_i == CLS_XCHG) && mem_dst_i);
  end
endmodule

// File: rtl/vm_guard_iomask.sv
module vm_guard_iomask #(
  parameter int WIN = 4
) (
  input  logic [1:0]     width_i,
  input  logic [WIN-1:0] bits_i,
  output logic           deny_o
);
  localparam int SPAN_W = $clog2(WIN) + 2;
  logic [WIN-1:0]    mask;
  logic [SPAN_W-1:0] span;

  always_comb begin
    case (width_i)
      2'd0:    span = SPAN_W'(1);
      2'd1:    span = SPAN_W'(2);
      default: span = SPAN_W'(4);
    endcase
  end

  for (genvar g = 0; g < WIN; g++) begin : g_mask
    assign mask[g] = SPAN_W'(g) < span;
  end

  assign deny_o = |(bits_i & mask);
endmodule

// File: rtl/vm_insn_guard.sv
module vm_insn_guard
  import vm_guard_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 15,
  parameter int PORT_W  = 16,
  parameter int WIN     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              lock_i,
  input  logic              mem_dst_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        iopl_i,
  input  logic [1:0]        cpl_i,
  input  logic              vm_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [1:0]        io_width_i,
  output logic              bm_req_o,
  output logic [PORT_W-1:0] bm_port_o,
  input  logic              bm_ack_i,
  input  logic [WIN-1:0]    bm_bits_i,
  output logic              done_o,
  output logic [1:0]        verdict_o,
  output logic [7:0]        vector_o,
  output logic              bus_lock_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e            state_q;
  verdict_e          pre_verd, verd_q;
  logic              need_bm, lock_bus, deny, accept;
  logic              done_q, lock_q, req_q;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        width_q;

  vm_guard_classify #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_classify (
    .cls_i, .lock_i, .mem_dst_i, .len_i, .iopl_i, .cpl_i, .vm_i,
    .verdict_o (pre_verd),
    .need_bm_o (need_bm),
    .lock_bus_o(lock_bus)
  );

  vm_guard_iomask #(.WIN(WIN)) u_iomask (
    .width_i(width_q),
    .bits_i (bm_bits_i),
    .deny_o (deny)
  );

  assign accept = valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      verd_q  <= VERD_PASS;
      lock_q  <= 1'b0;
      req_q   <= 1'b0;
      port_q  <= '0;
      width_q <= '0;
    end else begin
      done_q <= 1'b0;
      lock_q <= 1'b0;
      if (accept) begin
        if (need_bm) begin
          state_q <= ST_WAIT;
          req_q   <= 1'b1;
          port_q  <= port_i;
          width_q <= io_width_i;
        end else begin
          done_q <= 1'b1;
          verd_q <= pre_verd;
          lock_q <= (pre_verd == VERD_PASS) && lock_bus;
        end
      end else if ((state_q == ST_WAIT) && bm_ack_i) begin
        state_q <= ST_IDLE;
        req_q   <= 1'b0;
        done_q  <= 1'b1;
        verd_q  <= deny ? VERD_GP : VERD_PASS;
      end
    end
  end

  assign ready_o    = state_q == ST_IDLE;
  assign bm_req_o   = req_q;
  assign bm_port_o  = port_q;
  assign done_o     = done_q;
  assign verdict_o  = verd_q;
  assign vector_o   = vec_of(verd_q);
  assign bus_lock_o = lock_q;

  p_len_trap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && (int'(len_i) > MAX_LEN)) |=>
      (done_o && verdict_o == 2'd1 && vector_o == 8'd13));
  p_ud_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && verdict_o == 2'd2) |-> vector_o == 8'd6);
  p_pass_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && verdict_o == 2'd0) |-> vector_o == 8'd0);
  p_lock_on_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> (done_o && verdict_o == 2'd0));
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_req_o && !bm_ack_i) |=> (bm_req_o && $stable(bm_port_o)));
  p_ack_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_req_o && bm_ack_i) |=> (done_o && !bm_req_o));
  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_req_o |-> !ready_o);
endmodule

// File: tb/vm_insn_guard_bench.sv
module vm_insn_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 0, lock = 0, mem = 0, vm = 0, ack = 0;
  logic [4:0]  cls = 0, len = 1;
  logic [1:0]  iopl = 0, cpl = 0, width = 0;
  logic [15:0] port = 0;
  logic [3:0]  bits = 0;
  logic        ready, req, done, blk;
  logic [15:0] req_port;
  logic [1:0]  verd;
  logic [7:0]  vec;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_insn_guard u_vm_insn_guard (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .cls_i(cls), .lock_i(lock), .mem_dst_i(mem), .len_i(len),
    .iopl_i(iopl), .cpl_i(cpl), .vm_i(vm), .port_i(port), .io_width_i(width),
    .bm_req_o(req), .bm_port_o(req_port), .bm_ack_i(ack), .bm_bits_i(bits),
    .done_o(done), .verdict_o(verd), .vector_o(vec), .bus_lock_o(blk)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model of the first-stage decision
  function automatic void model(input logic [4:0] c, input logic lk, mm,
                                input logic [4:0] ln, input logic [1:0] io, cp,
                                input logic v, output logic [1:0] ev,
                                output logic nb, output logic bl, output string tag);
    logic [1:0] ec = v ? 2'd3 : cp;
    logic ok = ec <= io;
    logic lockable = c >= 16 && c <= 30;
    logic sens = (c == 1 || c == 2) || (v && ((c >= 3 && c <= 6) || lk));
    ev = 0; nb = 0;
    tag = v ? "R3" : "R6";
    if (ln > 15) begin ev = 1; tag = "R1"; end
    else if (lk && !(lockable && mm)) begin ev = 2; tag = "R2"; end
    else if (sens && !ok) ev = 1;
    else if (c >= 8 && c <= 11 && (v || !ok)) begin nb = 1; tag = v ? "R4" : "R7"; end
    else if (c >= 8 && c <= 11) tag = "R7";
    bl = (ev == 0) && !nb && ((lk && lockable && mm) || (c == 16 && mm));
  endfunction

  function automatic logic deny_of(input logic [1:0] w, input logic [3:0] b);
    logic [3:0] m = (w == 0) ? 4'h1 : (w == 1) ? 4'h3 : 4'hf;
    return |(b & m);
  endfunction

  task automatic run(input logic [4:0] c, input logic lk, mm, input logic [4:0] ln,
                     input logic [1:0] io, cp, input logic v, input logic [15:0] p,
                     input logic [1:0] w, input logic [3:0] b, input int dly);
    logic [1:0] ev; logic nb, bl; string tag;
    model(c, lk, mm, ln, io, cp, v, ev, nb, bl, tag);
    @(negedge clk);
    cls = c; lock = lk; mem = mm; len = ln; iopl = io; cpl = cp; vm = v;
    port = p; width = w; valid = 1;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    check(tag, "bm_req", {31'd0, req}, {31'd0, nb});
    if (nb) begin
      check("R9", "ready low while pending", {31'd0, ready}, 0);
      check(tag, "bm_port", {16'd0, req_port}, {16'd0, p});
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        check("R9", "req held", {31'd0, req}, 1);
        check("R9", "port stable", {16'd0, req_port}, {16'd0, p});
        check("R9", "no early verdict", {31'd0, done}, 0);
      end
      ack = 1; bits = b;
      @(posedge clk);
      @(negedge clk);
      ack = 0; bits = 4'hx;
      ev = deny_of(w, b) ? 2'd1 : 2'd0;
      tag = "R5";
      bl = 0;
      check("R9", "req dropped", {31'd0, req}, 0);
    end
    check(tag, "done", {31'd0, done}, 1);
    check(tag, "verdict", {30'd0, verd}, {30'd0, ev});
    check(tag, "vector", {24'd0, vec}, (ev == 1) ? 32'd13 : (ev == 2) ? 32'd6 : 32'd0);
    check("R8", "bus_lock", {31'd0, blk}, {31'd0, bl});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] pick [14] = '{0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 16, 20, 30};
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R10", "ready at reset", {31'd0, ready}, 1);
    check("R10", "done at reset", {31'd0, done}, 0);
    check("R10", "req at reset", {31'd0, req}, 0);
    rst_n = 1;
    // directed corners
    run(16, 1, 0, 16, 0, 0, 1, 16'h60, 0, 0, 0);   // R1 over R2
    run(16, 1, 1, 15, 3, 0, 1, 0, 0, 0, 0);        // legal lock, IOPL 3: pass with lock (R8)
    run(16, 1, 1, 15, 2, 0, 1, 0, 0, 0, 0);        // R3 lock sensitivity wins, no bus lock
    run(16, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0);         // exchange memory: implicit lock R8
    run(8, 1, 1, 2, 0, 0, 1, 0, 0, 0, 0);          // R2 lock on I/O
    run(5, 0, 0, 2, 2, 0, 1, 0, 0, 0, 0);          // R3 software interrupt traps
    run(4, 0, 0, 1, 3, 3, 1, 0, 0, 0, 0);          // R3 pass at IOPL 3
    run(1, 0, 0, 1, 3, 0, 1, 0, 0, 0, 0);          // R3 cpl input ignored
    run(3, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0);          // R6 pushf insensitive outside vm
    run(2, 0, 0, 1, 1, 2, 0, 0, 0, 0, 0);          // R6 sti traps
    run(10, 0, 0, 1, 3, 0, 1, 16'h3f8, 0, 4'hE, 2); // R4 ignores IOPL, R5 byte pass
    run(10, 0, 0, 1, 0, 0, 1, 16'h3f8, 1, 4'h2, 3); // R5 word deny upper byte
    run(9, 0, 0, 1, 0, 0, 1, 16'h20, 2, 4'h8, 0);   // R5 dword deny last byte
    run(11, 0, 0, 1, 2, 1, 0, 16'h40, 2, 4'hF, 0);  // R7 privileged, no request
    run(8, 0, 0, 1, 0, 3, 0, 16'h40, 1, 4'h0, 1);   // R7 falls back to bitmap
    run(8, 0, 0, 16, 0, 3, 1, 16'h40, 1, 4'h0, 0);  // R1 over R4
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] c = pick[$urandom_range(0, 13)];
      run(c, ($urandom_range(0, 3) == 0), $urandom_range(0, 1),
          5'($urandom_range(1, 18)), 2'($urandom), 2'($urandom), $urandom_range(0, 1),
          16'($urandom), 2'($urandom), 4'($urandom & $urandom), $urandom_range(0, 3));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule